// File: doc/BRIEF.md
# I2C Target Controller with Event Interrupts

This block is an I2C target (slave) that runs entirely on the system clock. It oversamples SCL and SDA and finds START, repeated START and STOP conditions. It compares the upper seven bits of each address byte with a programmable own address. After a match it either receives bytes and acknowledges each one, or it transmits the byte that software last placed in the data register. The bus pins are modelled as active-high pull-down enables, so the surrounding pad logic builds the open-drain driver.

Software reaches four byte-wide registers through a simple write strobe and a combinational read mux: a control register at index 0, event flags at index 1, the own address at index 2 and the data register at index 3. A single level interrupt collects four bus events, each gated by its own control bit. One of these enables works with inverted polarity. An option lets the target hold SCL low after the master refuses a transmitted byte, until software lets the bus go.

Top module: `i2c_target_evt`

## Requirements
- R1: After reset the control register and the flag register read 0x00, irq is 0, and scl_oe and sda_oe are both 0.
- R2: The control register keeps only bits 6..2 and bit 0. Bits 7 and 1 always read 0, so writing 0xFF reads back 0x7D.
- R3: An address byte whose bits 7..1 equal the own address is acknowledged on the ninth clock (SDA pulled low), and flag bit 0 (address-acknowledged) is set. Any other address is not acknowledged, and it clears flag bit 0.
- R4: With address bit 0 = 0, each received byte is acknowledged, can be read at index 3, and sets flag bit 3 (data ready). Flag bit 1 is set on START and flag bit 2 on STOP.
- R5: With address bit 0 = 1, the target sends the data register MSB first. It sends the same register again after every byte that the master acknowledges. A NACK from the master sets flag bit 4.
- R6: irq includes flag bit 1 (START) only while control bit 6 is 1.
- R7: irq includes flag bit 2 (STOP) only while control bit 5 is 1.
- R8: A repeated START followed by a non-matching address, while flag bit 0 is 1, sets flag bit 5. irq includes flag bit 5 while control bit 4 is 1.
- R9: A STOP seen while flag bit 0 is 0 sets flag bit 6. irq includes flag bit 6 while control bit 2 is 0. Setting control bit 2 to 1 masks it.
- R10: With control bit 3 = 1, a NACK after a transmitted byte makes the target hold SCL low. Writing index 1 with bit 7 = 1, or writing index 3, releases it. With control bit 3 = 0, SCL is never held.
- R11: While control bit 0 is 0, the flag register is forced to 0x00 and both pull-downs are released, including during a held SCL.
- R12: Writing 1 to a flag bit at index 1 clears it. Writing 0 leaves it unchanged. A hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | Resolved SCL line |
| sda_in | input | 1 | Resolved SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a START or STOP. They also assume that each line level is held for several system clocks longer than the synchronizer delay, and that the master waits while SCL is held low. The bench master meets these conditions. It holds every bus phase for eight system clocks, changes data only in the low phase, and waits for the resolved SCL to go high before it counts a high phase. Random own addresses, data bytes and enable patterns are drawn inside these limits.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_W = 8;

   localparam logic [1:0] RIX_CTRL = 2'd0;
   localparam logic [1:0] RIX_FLAG = 2'd1;
   localparam logic [1:0] RIX_OWN  = 2'd2;
   localparam logic [1:0] RIX_DATA = 2'd3;

   // control bit positions
   localparam int C_EN    = 0;
   localparam int C_FSTPN = 2;   // inverted: 0 enables foreign-stop interrupt
   localparam int C_HOLD  = 3;
   localparam int C_RMIE  = 4;
   localparam int C_STPIE = 5;
   localparam int C_STAIE = 6;
   localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h7D;

   // flag bit positions
   localparam int F_SEL   = 0;
   localparam int F_STA   = 1;
   localparam int F_STP   = 2;
   localparam int F_RDY   = 3;
   localparam int F_NAK   = 4;
   localparam int F_RMIS  = 5;
   localparam int F_FSTP  = 6;
   localparam int F_REL   = 7;   // write-only release strobe

   typedef enum logic [2:0] {
      PH_IDLE, PH_ADDR, PH_RX, PH_ACKO, PH_TX, PH_ACKI, PH_HOLD
   } phase_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("i2ct_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_d, sda_d;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_chain
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_ff[0] <= 1'b1;
                  sda_ff[0] <= 1'b1;
               end else begin
                  scl_ff[0] <= scl_in;
                  sda_ff[0] <= sda_in;
               end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_ff[i] <= 1'b1;
                  sda_ff[i] <= 1'b1;
               end else begin
                  scl_ff[i] <= scl_ff[i-1];
                  sda_ff[i] <= sda_ff[i-1];
               end
         end
      end
   endgenerate

   assign scl_q = scl_ff[STAGES-1];
   assign sda_q = sda_ff[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q;
         sda_d <= sda_q;
      end

   // an edge on one line counts only while the other line holds still
   assign scl_rise  =  scl_q & ~scl_d & (sda_q == sda_d);
   assign scl_fall  = ~scl_q &  scl_d & (sda_q == sda_d);
   assign start_det = ~sda_q &  sda_d & scl_q & scl_d;
   assign stop_det  =  sda_q & ~sda_d & scl_q & scl_d;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine import i2ct_pkg::*; #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              hold_en,
   input  logic              release_p,
   input  logic [ADDR_W-1:0] own,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              ev_start,
   output logic              ev_stop,
   output logic              ev_hit,
   output logic              ev_miss,
   output logic              ev_rx,
   output logic              ev_nack,
   output logic              restart,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              scl_oe,
   output logic              sda_oe
);
   generate
      if (ADDR_W != BYTE_W - 1) begin : g_bad
         $error("i2ct_engine: ADDR_W must be one less than BYTE_W");
      end
   endgenerate

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              full_q, rw_q, busy_q, nak_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0; full_q <= 1'b0;
         rw_q <= 1'b0; busy_q <= 1'b0; nak_q <= 1'b0; restart <= 1'b0;
         rx_byte <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
         ev_start <= 1'b0; ev_stop <= 1'b0; ev_hit <= 1'b0;
         ev_miss <= 1'b0; ev_rx <= 1'b0; ev_nack <= 1'b0;
      end else if (!en) begin
         phase_q <= PH_IDLE; full_q <= 1'b0; busy_q <= 1'b0;
         scl_oe <= 1'b0; sda_oe <= 1'b0;
         ev_start <= 1'b0; ev_stop <= 1'b0; ev_hit <= 1'b0;
         ev_miss <= 1'b0; ev_rx <= 1'b0; ev_nack <= 1'b0;
      end else begin
         ev_start <= start_det; ev_stop <= stop_det; ev_hit <= 1'b0;
         ev_miss <= 1'b0; ev_rx <= 1'b0; ev_nack <= 1'b0;
         if (start_det) begin
            phase_q <= PH_ADDR; cnt_q <= '0; full_q <= 1'b0;
            restart <= busy_q; busy_q <= 1'b1;
            scl_oe <= 1'b0; sda_oe <= 1'b0;
         end else if (stop_det) begin
            phase_q <= PH_IDLE; busy_q <= 1'b0;
            scl_oe <= 1'b0; sda_oe <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_ADDR, PH_RX: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_q};
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == LAST) full_q <= 1'b1;
                  end else if (scl_fall && full_q) begin
                     full_q <= 1'b0;
                     cnt_q  <= '0;
                     if (phase_q == PH_ADDR) begin
                        if (sh_q[BYTE_W-1:1] == own) begin
                           ev_hit <= 1'b1; sda_oe <= 1'b1;
                           rw_q <= sh_q[0]; phase_q <= PH_ACKO;
                        end else begin
                           ev_miss <= 1'b1; phase_q <= PH_IDLE;
                        end
                     end else begin
                        ev_rx <= 1'b1; rx_byte <= sh_q;
                        sda_oe <= 1'b1; phase_q <= PH_ACKO;
                     end
                  end
               end
               PH_ACKO: if (scl_fall) begin
                  cnt_q <= '0;
                  if (rw_q) begin
                     sh_q <= tx_byte; sda_oe <= ~tx_byte[BYTE_W-1];
                     phase_q <= PH_TX;
                  end else begin
                     sda_oe <= 1'b0; phase_q <= PH_RX;
                  end
               end
               PH_TX: if (scl_fall) begin
                  if (cnt_q == LAST) begin
                     sda_oe <= 1'b0; phase_q <= PH_ACKI;
                  end else begin
                     sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~sh_q[BYTE_W-2];
                     cnt_q  <= cnt_q + 1'b1;
                  end
               end
               PH_ACKI: begin
                  if (scl_rise) begin
                     nak_q <= sda_q; ev_nack <= sda_q;
                  end else if (scl_fall) begin
                     if (nak_q) begin
                        if (hold_en) begin
                           scl_oe <= 1'b1; phase_q <= PH_HOLD;
                        end else phase_q <= PH_IDLE;
                     end else begin
                        sh_q <= tx_byte; sda_oe <= ~tx_byte[BYTE_W-1];
                        cnt_q <= '0; phase_q <= PH_TX;
                     end
                  end
               end
               PH_HOLD: if (release_p) begin
                  scl_oe <= 1'b0; phase_q <= PH_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assert_hold_needs_opt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(hold_en));
   assert_off_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs import i2ct_pkg::*; #(
   parameter int              ADDR_W  = 7,
   parameter logic [ADDR_W-1:0] RST_OWN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_hit,
   input  logic              ev_miss,
   input  logic              ev_rx,
   input  logic              ev_nack,
   input  logic              restart,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              en,
   output logic              hold_en,
   output logic [ADDR_W-1:0] own,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              release_p,
   output logic              irq
);
   logic [BYTE_W-1:0] ctrl_q, flag_q, flag_n, rx_q;

   always_comb begin
      flag_n = flag_q;
      if (wr && addr == RIX_FLAG) flag_n = flag_n & ~(wdata & ~(8'h1 << F_REL));
      if (ev_hit)   flag_n[F_SEL] = 1'b1;
      if (ev_miss)  flag_n[F_SEL] = 1'b0;
      if (ev_start) flag_n[F_STA] = 1'b1;
      if (ev_stop)  flag_n[F_STP] = 1'b1;
      if (ev_rx)    flag_n[F_RDY] = 1'b1;
      if (ev_nack)  flag_n[F_NAK] = 1'b1;
      if (ev_miss && flag_q[F_SEL] && restart) flag_n[F_RMIS] = 1'b1;
      if (ev_stop && !flag_q[F_SEL])           flag_n[F_FSTP] = 1'b1;
      if (!ctrl_q[C_EN]) flag_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; flag_q <= '0; own <= RST_OWN; tx_byte <= '0; rx_q <= '0;
      end else begin
         flag_q <= flag_n;
         if (ev_rx) rx_q <= rx_byte;
         if (wr) begin
            unique case (addr)
               RIX_CTRL: ctrl_q  <= wdata & CTRL_MASK;
               RIX_OWN:  own     <= wdata[ADDR_W-1:0];
               RIX_DATA: tx_byte <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (addr)
         RIX_CTRL: rdata = ctrl_q;
         RIX_FLAG: rdata = flag_q;
         RIX_OWN:  rdata = BYTE_W'(own);
         default:  rdata = rx_q;
      endcase
   end

   assign en        = ctrl_q[C_EN];
   assign hold_en   = ctrl_q[C_HOLD];
   assign release_p = wr && ((addr == RIX_FLAG && wdata[F_REL]) || addr == RIX_DATA);
   assign irq = (flag_q[F_STA]  & ctrl_q[C_STAIE]) | (flag_q[F_STP] & ctrl_q[C_STPIE])
              | (flag_q[F_RMIS] & ctrl_q[C_RMIE])  | (flag_q[F_FSTP] & ~ctrl_q[C_FSTPN]);

   assert_hit_sets_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hit && en) |=> flag_q[F_SEL]);
   assert_stop_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && en && ctrl_q[C_STPIE] && !(wr && addr == RIX_CTRL)) |=> irq);
   assert_rmis_after_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[F_RMIS]) |-> $past(flag_q[F_SEL]));
   assert_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (flag_q == '0));
endmodule

// File: rtl/i2c_target_evt.sv
module i2c_target_evt import i2ct_pkg::*; #(
   parameter int                SYNC_STAGES  = 2,
   parameter int                ADDR_W       = 7,
   parameter logic [ADDR_W-1:0] RST_OWN_ADDR = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       irq
);
   logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic en, hold_en, release_p, restart;
   logic ev_start, ev_stop, ev_hit, ev_miss, ev_rx, ev_nack;
   logic [ADDR_W-1:0] own;
   logic [BYTE_W-1:0] tx_byte, rx_byte;

   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2ct_engine #(.ADDR_W(ADDR_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .hold_en(hold_en), .release_p(release_p),
      .own(own), .tx_byte(tx_byte), .sda_q(sda_q), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .ev_start(ev_start), .ev_stop(ev_stop), .ev_hit(ev_hit), .ev_miss(ev_miss),
      .ev_rx(ev_rx), .ev_nack(ev_nack), .restart(restart), .rx_byte(rx_byte),
      .scl_oe(scl_oe), .sda_oe(sda_oe));

   i2ct_regs #(.ADDR_W(ADDR_W), .RST_OWN(RST_OWN_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .ev_start(ev_start), .ev_stop(ev_stop), .ev_hit(ev_hit),
      .ev_miss(ev_miss), .ev_rx(ev_rx), .ev_nack(ev_nack), .restart(restart),
      .rx_byte(rx_byte), .en(en), .hold_en(hold_en), .own(own), .tx_byte(tx_byte),
      .release_p(release_p), .irq(irq));

   // scl_q is kept for the structure of the synchronizer; only edges are used
   logic unused_scl;
   assign unused_scl = scl_q;
endmodule

// File: tb/sim_i2c_target_evt.sv
module sim_i2c_target_evt;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0, bus_rdata;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_oe, sda_oe, irq;
   wire  scl = scl_m & ~scl_oe;
   wire  sda = sda_m & ~sda_oe;
   int errors = 0, checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_target_evt u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl), .sda_in(sda),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

   function automatic logic exp_irq(input logic [7:0] c, input logic [7:0] f);
      return (f[1] & c[6]) | (f[2] & c[5]) | (f[5] & c[4]) | (f[6] & ~c[2]);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic qwait; repeat (Q) @(negedge clk); endtask

   task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; #1 d = bus_rdata;
   endtask

   task automatic flags_irq(input string req, input logic [7:0] c, input logic [7:0] f);
      logic [7:0] v;
      reg_rd(2'd1, v);
      check({req, " flags"}, v, f);
      check({req, " irq"}, {7'd0, irq}, {7'd0, exp_irq(c, f)});
   endtask

   task automatic scl_pulse(output logic s);
      scl_m = 1'b1;
      while (scl !== 1'b1) @(negedge clk);
      qwait; s = sda; scl_m = 1'b0; qwait;
   endtask

   task automatic m_start;
      sda_m = 1'b1; scl_m = 1'b1; qwait; sda_m = 1'b0; qwait; scl_m = 1'b0; qwait;
   endtask
   task automatic m_restart;
      sda_m = 1'b1; qwait; scl_m = 1'b1; qwait; sda_m = 1'b0; qwait; scl_m = 1'b0; qwait;
   endtask
   task automatic m_stop;
      sda_m = 1'b0; qwait; scl_m = 1'b1; qwait; sda_m = 1'b1; qwait;
   endtask

   task automatic m_write(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; qwait; scl_pulse(s);
      end
      sda_m = 1'b1; qwait; scl_pulse(s); ack = ~s;
   endtask

   task automatic m_read(output logic [7:0] b, input logic nack);
      logic s;
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         qwait; scl_pulse(s); b = {b[6:0], s};
      end
      sda_m = nack; qwait; scl_pulse(s); sda_m = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v, d, c;
      logic [6:0] own;
      logic ack;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      reg_rd(2'd0, v); check("R1 ctrl", v, 8'h00);
      reg_rd(2'd1, v); check("R1 flags", v, 8'h00);
      check("R1 pins", {5'd0, irq, scl_oe, sda_oe}, 8'h00);

      // R2 reserved control bits
      reg_wr(2'd0, 8'hFF); reg_rd(2'd0, v); check("R2 ctrl mask", v, 8'h7D);
      reg_wr(2'd0, 8'h00);

      // R3 R4 R6 R7 R12 random receive transfers
      for (int k = 0; k < 6; k++) begin
         own = 7'($urandom);
         c = 8'h01 | (8'($urandom) & 8'h74);
         d = 8'($urandom);
         reg_wr(2'd2, {1'b0, own}); reg_wr(2'd0, c); reg_wr(2'd1, 8'h7F);
         m_start;
         m_write({own, 1'b0}, ack); check("R3 addr ack", {7'd0, ack}, 8'h01);
         m_write(d, ack);           check("R4 data ack", {7'd0, ack}, 8'h01);
         m_stop;
         reg_rd(2'd3, v); check("R4 rx byte", v, d);
         flags_irq("R4 R6 R7", c, 8'h0F);
         reg_wr(2'd1, 8'h7F); flags_irq("R12 clear", c, 8'h00);
      end

      // R12 partial clear leaves other bits
      reg_wr(2'd0, 8'h61); reg_wr(2'd1, 8'h7F);
      m_start; m_write({own, 1'b0}, ack); m_stop;
      reg_wr(2'd1, 8'h02); flags_irq("R12 partial", 8'h61, 8'h05);

      // R5 transmit
      for (int k = 0; k < 3; k++) begin
         d = 8'($urandom);
         reg_wr(2'd3, d); reg_wr(2'd1, 8'h7F);
         m_start;
         m_write({own, 1'b1}, ack); check("R5 addr ack", {7'd0, ack}, 8'h01);
         m_read(v, 1'b0); check("R5 byte 1", v, d);
         m_read(v, 1'b1); check("R5 byte 2", v, d);
         m_stop;
         flags_irq("R5", 8'h61, 8'h17);
      end

      // R3 R9 foreign address and foreign stop
      reg_wr(2'd0, 8'h01); reg_wr(2'd1, 8'h7F);
      m_start; m_write({own ^ 7'h01, 1'b0}, ack); m_stop;
      check("R3 no ack foreign", {7'd0, ack}, 8'h00);
      flags_irq("R9 foreign stop enabled", 8'h01, 8'h46);
      reg_wr(2'd0, 8'h05); reg_wr(2'd1, 8'h7F);
      m_start; m_write({own ^ 7'h01, 1'b0}, ack); m_stop;
      flags_irq("R9 foreign stop masked", 8'h05, 8'h46);

      // R8 restart to another target
      reg_wr(2'd0, 8'h15); reg_wr(2'd1, 8'h7F);
      m_start; m_write({own, 1'b0}, ack); m_write(8'h3C, ack);
      m_restart; m_write({own ^ 7'h01, 1'b0}, ack);
      check("R8 no ack", {7'd0, ack}, 8'h00);
      flags_irq("R8 mismatch", 8'h15, 8'h2A);
      m_stop;
      flags_irq("R8 after stop", 8'h15, 8'h6E);

      // R10 hold on NACK, released by software
      reg_wr(2'd0, 8'h09); reg_wr(2'd1, 8'h7F); reg_wr(2'd3, 8'hA5);
      m_start; m_write({own, 1'b1}, ack); m_read(v, 1'b1);
      check("R10 tx byte", v, 8'hA5);
      scl_m = 1'b1; repeat (3*Q) @(negedge clk);
      check("R10 scl held", {7'd0, scl}, 8'h00);
      reg_rd(2'd1, v); check("R10 nack flag", v & 8'h10, 8'h10);
      sda_m = 1'b0; qwait;
      reg_wr(2'd1, 8'h80); qwait;
      check("R10 scl released", {7'd0, scl}, 8'h01);
      sda_m = 1'b1; qwait;

      // R10 no hold when option off
      reg_wr(2'd0, 8'h01); reg_wr(2'd1, 8'h7F);
      m_start; m_write({own, 1'b1}, ack); m_read(v, 1'b1);
      scl_m = 1'b1; repeat (3*Q) @(negedge clk);
      check("R10 no hold", {6'd0, scl, scl_oe}, 8'h02);
      scl_m = 1'b0; qwait; m_stop;

      // R11 disable during hold
      reg_wr(2'd0, 8'h09); reg_wr(2'd1, 8'h7F);
      m_start; m_write({own, 1'b1}, ack); m_read(v, 1'b1);
      scl_m = 1'b1; repeat (3*Q) @(negedge clk);
      check("R11 held before disable", {7'd0, scl}, 8'h00);
      reg_wr(2'd0, 8'h00); qwait;
      check("R11 pins released", {6'd0, scl_oe, sda_oe}, 8'h00);
      reg_rd(2'd1, v); check("R11 flags zero", v, 8'h00);
      sda_m = 1'b1; qwait;

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule